// File: doc/BRIEF.md
# Colour Lookup Palette with Auto-Stepping Host Access

This block holds a 256-entry colour table used to turn an 8-bit pixel code into three 6-bit colour intensities. Software reaches the table through four byte-wide ports that share one select field. One port sets the entry a fill begins at. One sets the entry a readout begins at. One carries the colour bytes themselves. One holds a pixel mask.

A hidden three-state colour counter steps through red, green and blue on each data-port access. After the third byte the entry pointer moves to the next entry, and it wraps from the last entry to the first. A full table can therefore be loaded or dumped with one index write followed by a stream of data bytes. Fill and readout keep separate pointers and counters. Red and green are held in staging registers until blue arrives, and then all three are written to the table in one cycle. The display path therefore never sees an entry that is only partly updated.

On the display side, the pixel code is ANDed with the mask and looked up in the table. The colour appears one clock later.

Top module: `clut_port`

## Requirements
- R1: A host write with `host_sel`=0 loads the fill pointer from `host_wdata` and returns the fill colour counter to red, so the next three data bytes go to that entry even if a fill was left part-way.
- R2: Host writes with `host_sel`=2 supply red, green and blue of the entry at the fill pointer, in that order. The fill pointer advances by one only after the blue byte.
- R3: The fill pointer wraps from 255 to 0. After a complete 256-entry fill, a host read with `host_sel`=0 returns 0.
- R4: A host write with `host_sel`=1 loads the readout pointer and returns the readout colour counter to red. Successive host reads with `host_sel`=2 return red, green and blue of that entry and then move on to the next entry. Each read result is on `host_rdata` after the clock edge that samples `host_re`.
- R5: Only bits 5:0 of each written colour byte are stored. A data-port read returns the stored value in bits 5:0, with bits 7:6 equal to zero.
- R6: The mask (`host_sel`=3, read and written through the same port) is ANDed bitwise with `pix_idx` before the lookup. Its reset value 0xFF leaves every pixel code unmasked.
- R7: After only red and green of an entry have been written, the pixel path still shows that entry's previous colour. The new colour appears on the pixel path only after the blue write.
- R8: `pix_r`/`pix_g`/`pix_b` show the entry selected by the `pix_idx` sampled at a clock edge, from that edge until the next one. Latency is one cycle, and a new code can be given every cycle.
- R9: Reset (synchronous, active high) clears both pointers, sets both colour counters to red, sets the mask to 0xFF, and holds `host_rdata` and the pixel outputs at zero.
- R10: The readout pointer wraps from 255 to 0 after the blue byte of entry 255 has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write strobe for the selected port |
| host_re | input | 1 | Host read strobe for the selected port |
| host_sel | input | 2 | Port select: 0 fill index, 1 readout index, 2 colour data, 3 pixel mask |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| pix_idx | input | 8 | Pixel code to look up |
| pix_r | output | 6 | Red intensity |
| pix_g | output | 6 | Green intensity |
| pix_b | output | 6 | Blue intensity |

## Verification
Every result the block produces is due one cycle after its stimulus. A host read is sampled at one clock edge and its byte is on `host_rdata` after that edge. A pixel code is sampled at one edge and its colour is on the outputs after that edge. A blue write changes the table at its edge, so a lookup driven in the following cycle shows the new colour. The driver records each expected item together with the number of the cycle in which it falls due. The monitor compares items at the falling edge of exactly that cycle. Back-to-back pixel codes therefore confirm the single-cycle latency, and a queue that has not drained at the end counts as a failure.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int IDX_W = 8;
    localparam int CLR_W = 6;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        SEL_WIDX = 2'd0,
        SEL_RIDX = 2'd1,
        SEL_DATA = 2'd2,
        SEL_MASK = 2'd3
    } port_sel_e;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_e;

    typedef struct packed {
        logic [CLR_W-1:0] r;
        logic [CLR_W-1:0] g;
        logic [CLR_W-1:0] b;
    } rgb_t;

    function automatic comp_e comp_next(input comp_e c);
        case (c)
            COMP_R:  return COMP_G;
            COMP_G:  return COMP_B;
            default: return COMP_R;
        endcase
    endfunction

    function automatic logic [CLR_W-1:0] comp_pick(input rgb_t e, input comp_e c);
        case (c)
            COMP_R:  return e.r;
            COMP_G:  return e.g;
            default: return e.b;
        endcase
    endfunction

endpackage

// File: rtl/clut_ram.sv
module clut_ram
    import clut_pkg::*;
#(
    parameter int AW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rgb_t          wdata,
    input  logic [AW-1:0] pix_addr,
    output rgb_t          pix_q,
    input  logic [AW-1:0] host_addr,
    output rgb_t          host_q
);
    localparam int DEPTH = 1 << AW;

    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Pixel port: registered read, returns old contents on a same-edge write.
    always_ff @(posedge clk) begin
        if (rst) pix_q <= '0;
        else     pix_q <= mem[pix_addr];
    end

    assign host_q = mem[host_addr];
endmodule

// File: rtl/clut_host_seq.sv
module clut_host_seq
    import clut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic             host_re,
    input  port_sel_e        sel,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    output logic [IDX_W-1:0] wr_ptr,
    output comp_e            wr_comp,
    output logic [IDX_W-1:0] rd_ptr,
    output comp_e            rd_comp,
    output logic [IDX_W-1:0] mask,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_waddr,
    output rgb_t             ram_wdata,
    input  rgb_t             host_q
);
    logic [CLR_W-1:0] stage_r, stage_g;
    logic             data_wr, data_rd;

    assign data_wr   = host_we && (sel == SEL_DATA);
    assign data_rd   = host_re && (sel == SEL_DATA);
    assign ram_we    = data_wr && (wr_comp == COMP_B);
    assign ram_waddr = wr_ptr;
    assign ram_wdata = '{r: stage_r, g: stage_g, b: host_wdata[CLR_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            wr_comp    <= COMP_R;
            stage_r    <= '0;
            stage_g    <= '0;
            mask       <= '1;
        end else if (host_we) begin
            case (sel)
                SEL_WIDX: begin
                    wr_ptr  <= host_wdata[IDX_W-1:0];
                    wr_comp <= COMP_R;
                end
                SEL_MASK: mask <= host_wdata[IDX_W-1:0];
                SEL_DATA: begin
                    if (wr_comp == COMP_R) stage_r <= host_wdata[CLR_W-1:0];
                    if (wr_comp == COMP_G) stage_g <= host_wdata[CLR_W-1:0];
                    if (wr_comp == COMP_B) wr_ptr  <= wr_ptr + 1'b1;
                    wr_comp <= comp_next(wr_comp);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr     <= '0;
            rd_comp    <= COMP_R;
            host_rdata <= '0;
        end else begin
            if (host_we && sel == SEL_RIDX) begin
                rd_ptr  <= host_wdata[IDX_W-1:0];
                rd_comp <= COMP_R;
            end else if (data_rd) begin
                if (rd_comp == COMP_B) rd_ptr <= rd_ptr + 1'b1;
                rd_comp <= comp_next(rd_comp);
            end
            if (host_re) begin
                case (sel)
                    SEL_WIDX: host_rdata <= BUS_W'(wr_ptr);
                    SEL_RIDX: host_rdata <= BUS_W'(rd_ptr);
                    SEL_MASK: host_rdata <= BUS_W'(mask);
                    default:  host_rdata <= BUS_W'(comp_pick(host_q, rd_comp));
                endcase
            end
        end
    end
endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic             host_re,
    input  logic [1:0]       host_sel,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [CLR_W-1:0] pix_r,
    output logic [CLR_W-1:0] pix_g,
    output logic [CLR_W-1:0] pix_b
);
    logic [IDX_W-1:0] wr_ptr, rd_ptr, mask, ram_waddr, pix_addr;
    comp_e            wr_comp, rd_comp;
    logic             ram_we;
    rgb_t             ram_wdata, pix_q, host_q;

    clut_host_seq u_seq (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_re(host_re),
        .sel(port_sel_e'(host_sel)),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .wr_ptr(wr_ptr), .wr_comp(wr_comp),
        .rd_ptr(rd_ptr), .rd_comp(rd_comp),
        .mask(mask),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .host_q(host_q)
    );

    assign pix_addr = pix_idx & mask;

    clut_ram #(.AW(IDX_W)) u_ram (
        .clk(clk), .rst(rst),
        .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .pix_addr(pix_addr), .pix_q(pix_q),
        .host_addr(rd_ptr), .host_q(host_q)
    );

    assign pix_r = pix_q.r;
    assign pix_g = pix_q.g;
    assign pix_b = pix_q.b;
endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk
    import clut_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_we,
    input logic             host_re,
    input logic [1:0]       host_sel,
    input logic [BUS_W-1:0] host_wdata,
    input logic [BUS_W-1:0] host_rdata,
    input logic [CLR_W-1:0] pix_r,
    input logic [CLR_W-1:0] pix_g,
    input logic [CLR_W-1:0] pix_b,
    input logic [IDX_W-1:0] wr_ptr,
    input logic [1:0]       wr_comp,
    input logic [IDX_W-1:0] rd_ptr,
    input logic [1:0]       rd_comp,
    input logic             ram_we
);
    // R1
    widx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel == 2'd0) |=>
            (wr_ptr == $past(host_wdata[IDX_W-1:0]) && wr_comp == COMP_R));

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel == 2'd2 && wr_comp != COMP_B) |=> $stable(wr_ptr));

    // R3
    ptr_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel == 2'd2 && wr_comp == COMP_B) |=>
            (wr_ptr == $past(wr_ptr) + 8'd1));

    // R4
    rptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_re && !host_we && host_sel == 2'd2 && rd_comp != COMP_B) |=> $stable(rd_ptr));

    // R10
    rptr_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (host_re && !host_we && host_sel == 2'd2 && rd_comp == COMP_B) |=>
            (rd_ptr == $past(rd_ptr) + 8'd1));

    // R5
    rdata_hi_chk: assert property (@(posedge clk) disable iff (rst)
        $past(host_re && host_sel == 2'd2) |-> (host_rdata[BUS_W-1:CLR_W] == '0));

    // R7
    commit_end_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> (wr_comp == COMP_R));

    // R9
    rst_pix_chk: assert property (@(posedge clk)
        rst |=> (pix_r == '0 && pix_g == '0 && pix_b == '0 && host_rdata == '0));
endmodule

bind clut_port clut_port_chk chk_i (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_re(host_re), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .wr_ptr(wr_ptr), .wr_comp(wr_comp),
    .rd_ptr(rd_ptr), .rd_comp(rd_comp),
    .ram_we(ram_we)
);

// File: tb/clut_port_tb_top.sv
module clut_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0, host_re = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'd0, pix_idx = 8'd0;
    logic [7:0] host_rdata;
    logic [5:0] pix_r, pix_g, pix_b;

    always #10 clk = ~clk;

    clut_port dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_idx(pix_idx), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    typedef struct {
        int          due;
        bit          is_pix;
        string       req;
        logic [17:0] exp;
    } item_t;

    item_t       sbq[$];
    item_t       mit;
    logic [17:0] mact;
    logic [17:0] model [256];
    int          cyc = 0, n_run = 0, n_fail = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [5:0] cr(input int i); return 6'(i); endfunction
    function automatic logic [5:0] cg(input int i); return 6'(i * 5 + 1); endfunction
    function automatic logic [5:0] cb(input int i); return 6'((i >> 2) ^ 8'h2A); endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare each item on the falling edge of its due cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            mit  = sbq.pop_front();
            mact = mit.is_pix ? {pix_r, pix_g, pix_b} : {10'd0, host_rdata};
            check(mit.req, mact, mit.exp);
        end
    end

    task automatic hw(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_re = 1'b0; host_sel = s; host_wdata = d;
    endtask

    task automatic hr(input logic [1:0] s, input logic [7:0] exp, input string req);
        item_t it;
        @(negedge clk);
        host_we = 1'b0; host_re = 1'b1; host_sel = s;
        it.due = cyc + 1; it.is_pix = 0; it.req = req; it.exp = {10'd0, exp};
        sbq.push_back(it);
    endtask

    task automatic px(input logic [7:0] idx, input logic [17:0] exp, input string req);
        item_t it;
        @(negedge clk);
        host_we = 1'b0; host_re = 1'b0; pix_idx = idx;
        it.due = cyc + 1; it.is_pix = 1; it.req = req; it.exp = exp;
        sbq.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        host_we = 1'b0; host_re = 1'b0;
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: outputs held at zero in reset
        check("R9", {pix_r, pix_g, pix_b}, 18'd0);
        check("R9", {10'd0, host_rdata}, 18'd0);
        rst = 1'b0;
        hr(2'd0, 8'h00, "R9");
        hr(2'd1, 8'h00, "R9");
        hr(2'd3, 8'hFF, "R9");

        // R2/R3/R5: full fill with junk in bits 7:6
        hw(2'd0, 8'h00);
        for (int i = 0; i < 256; i++) begin
            hw(2'd2, {2'b10, cr(i)});
            hw(2'd2, {2'b01, cg(i)});
            hw(2'd2, {2'b11, cb(i)});
            model[i] = {cr(i), cg(i), cb(i)};
        end
        hr(2'd0, 8'h00, "R3");

        // R8/R6: back-to-back lookups, mask open
        px(8'd0,   model[0],   "R8");
        px(8'd255, model[255], "R8");
        px(8'd128, model[128], "R8");
        px(8'd77,  model[77],  "R6");

        // R6: mask applied
        hw(2'd3, 8'h0F);
        hr(2'd3, 8'h0F, "R6");
        px(8'hF3, model[8'h03], "R6");
        px(8'h5A, model[8'h0A], "R6");
        hw(2'd3, 8'hFF);
        px(8'hF3, model[8'hF3], "R6");

        // R4/R5: readout stream across an entry boundary
        hw(2'd1, 8'd10);
        for (int i = 10; i < 12; i++) begin
            hr(2'd2, {2'b00, cr(i)}, "R4");
            hr(2'd2, {2'b00, cg(i)}, "R4");
            hr(2'd2, {2'b00, cb(i)}, "R5");
        end
        // R10: readout wrap
        hw(2'd1, 8'd255);
        hr(2'd2, {2'b00, cr(255)}, "R10");
        hr(2'd2, {2'b00, cg(255)}, "R10");
        hr(2'd2, {2'b00, cb(255)}, "R10");
        hr(2'd2, {2'b00, cr(0)},   "R10");
        hr(2'd1, 8'h00, "R10");

        // R7: staging holds red/green until blue
        hw(2'd0, 8'd20);
        hw(2'd2, 8'h11);
        hw(2'd2, 8'h22);
        px(8'd20, model[20], "R7");
        hw(2'd2, 8'h33);
        model[20] = {6'h11, 6'h22, 6'h33};
        px(8'd20, model[20], "R7");
        hr(2'd0, 8'd21, "R2");

        // R1: index write abandons a partial fill
        hw(2'd0, 8'd30);
        hw(2'd2, 8'h3F);
        hw(2'd0, 8'd40);
        hr(2'd0, 8'd40, "R1");
        hw(2'd2, 8'h05);
        hw(2'd2, 8'h06);
        hw(2'd2, 8'h07);
        model[40] = {6'h05, 6'h06, 6'h07};
        hr(2'd0, 8'd41, "R1");
        px(8'd30, model[30], "R1");
        px(8'd40, model[40], "R1");

        repeat (4) idle();
        if (sbq.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        done = 1;
        finish_up();
    end
endmodule